// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block does the byte-lane merging behind partial-word load and store instructions. A pair of these instructions can move a 32-bit word that sits at any byte address, even one that crosses an aligned word boundary. Each instruction reads the aligned memory word that holds its effective address, with the low two address bits cleared. The low two bits then pick which bytes of that word are merged with the current register value. Lanes use little-endian numbering: lane 0 is bits 7:0.

There are four operations, chosen by `op_i`: load-left (0), load-right (1), store-left (2) and store-right (3).
- For a load, `merged_o` is the new register value.
- For a store, `merged_o` is the word to write back to the aligned address.

`byte_en_o` marks the lanes that come from the other operand. For a load those are memory bytes landing in the register. For a store those are register bytes landing in memory. A byte-addressable memory can use this mask as a write strobe and skip the read-modify-write cycle. The block is purely combinational.

Top module: `unaligned_merge`

## Requirements
- R1: Load-left (op 0) at offsets 0,1,2,3 gives {mem[7:0],reg[23:0]}, {mem[15:0],reg[15:0]}, {mem[23:0],reg[7:0]} and mem.
- R2: Load-right (op 1) at offsets 1,2,3 gives {reg[31:24],mem[31:8]}, {reg[31:16],mem[31:16]} and {reg[31:8],mem[31:24]}.
- R3: Load-right at offset 0 returns the register value unchanged, with a byte-enable of 0000.
- R4: Store-left (op 2) at offsets 0,1,2,3 gives {mem[31:8],reg[31:24]}, {mem[31:16],reg[31:16]}, {mem[31:24],reg[31:8]} and reg.
- R5: Store-right (op 3) at offsets 0,1,2,3 gives reg, {reg[23:0],mem[7:0]}, {reg[15:0],mem[15:0]} and {reg[7:0],mem[23:0]}.
- R6: `byte_en_o` (bit n = lane n, bits 8n+7:8n) is listed by offset 0..3 as follows:
  - op 0: 1000, 1100, 1110, 1111
  - op 1: 0000, 0111, 0011, 0001
  - op 2: 0001, 0011, 0111, 1111
  - op 3: 1111, 1110, 1100, 1000
- R7: Every lane whose enable bit is 0 carries the destination operand unchanged. The destination is the register for loads and the memory word for stores.
- R8: A load-right at unaligned address A, followed by a load-left at A+3 on the resulting register, yields the little-endian word at bytes A..A+3, for every value of A mod 4.
- R9: A store-right at A, followed by a store-left at A+3 (each a merge and write-back of its aligned word), puts the register bytes at A..A+3 and leaves bytes A-1 and A+4 unchanged, for every value of A mod 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| offs_i | input | 2 | Low bits of the effective address |
| mem_word_i | input | 32 | Aligned memory word |
| reg_word_i | input | 32 | Current register value |
| merged_o | output | 32 | Merged register value (loads) or write-back word (stores) |
| byte_en_o | output | 4 | Lanes taken from the source operand |

## Verification
The bench sweeps every operation at every offset with two operand patterns, so a swapped shift direction or an off-by-one lane boundary shows up as whole bytes in the wrong lanes. Load-right at offset 0 is targeted on its own: a design that treats it like the other right-hand cases would overwrite the register with the full memory word, and would report a full mask instead of an empty one. Load pairs and store pairs are run against a byte array at all four alignments. A design whose left and right masks do not meet exactly would drop or duplicate a byte at the seam, or would clobber the neighbouring bytes in memory.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

    localparam int LANE_W_DEF = 8;
    localparam int LANES_DEF  = 4;

    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'd0,
        OP_LOAD_RIGHT  = 2'd1,
        OP_STORE_LEFT  = 2'd2,
        OP_STORE_RIGHT = 2'd3
    } merge_op_e;

    // How an operation routes its operands through the merge datapath.
    typedef struct packed {
        logic is_store;  // source is the register, destination the memory word
        logic shift_up;  // source moves towards higher lanes
    } route_t;

    function automatic route_t op_route(input merge_op_e op);
        route_t r;
        r.is_store = (op == OP_STORE_LEFT) || (op == OP_STORE_RIGHT);
        r.shift_up = (op == OP_LOAD_LEFT)  || (op == OP_STORE_RIGHT);
        return r;
    endfunction

endpackage

// File: rtl/ulm_lane_mask.sv
module ulm_lane_mask
    import ulm_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int OFFS_W = 2
) (
    input  merge_op_e         op_i,
    input  logic [OFFS_W-1:0] offs_i,
    output logic [LANES-1:0]  mask_o,
    output logic [OFFS_W-1:0] shamt_o
);

    localparam logic [OFFS_W-1:0] TOP_LANE = OFFS_W'(LANES - 1);

    always_comb begin
        int k;
        k = int'(offs_i);
        for (int l = 0; l < LANES; l++) begin
            unique case (op_i)
                OP_LOAD_LEFT:   mask_o[l] = (l >= LANES - 1 - k);
                OP_LOAD_RIGHT:  mask_o[l] = (k != 0) && (l <= LANES - 1 - k);
                OP_STORE_LEFT:  mask_o[l] = (l <= k);
                default:        mask_o[l] = (l >= k);
            endcase
        end
    end

    // Left-hand ops move by the distance to the top lane, right-hand ops by the offset.
    always_comb begin
        if (op_i == OP_LOAD_LEFT || op_i == OP_STORE_LEFT)
            shamt_o = TOP_LANE - offs_i;
        else
            shamt_o = offs_i;
    end

endmodule

// File: rtl/ulm_aligner.sv
module ulm_aligner
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int OFFS_W = 2
) (
    input  logic [LANE_W*LANES-1:0] src_i,
    input  logic                    shift_up_i,
    input  logic [OFFS_W-1:0]       shamt_i,
    output logic [LANE_W*LANES-1:0] aligned_o
);

    always_comb begin
        int unsigned bits;
        bits = int'(shamt_i) * LANE_W;
        if (shift_up_i)
            aligned_o = src_i << bits;
        else
            aligned_o = src_i >> bits;
    end

endmodule

// File: rtl/ulm_lane_merge.sv
module ulm_lane_merge
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] aligned_i,
    input  logic [LANE_W*LANES-1:0] dst_i,
    input  logic [LANES-1:0]        mask_i,
    output logic [LANE_W*LANES-1:0] merged_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*LANE_W +: LANE_W] =
            mask_i[g] ? aligned_i[g*LANE_W +: LANE_W] : dst_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/unaligned_merge.sv
module unaligned_merge
    import ulm_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    localparam int WORD_W = LANE_W * LANES,
    localparam int OFFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [1:0]        op_i,
    input  logic [OFFS_W-1:0] offs_i,
    input  logic [WORD_W-1:0] mem_word_i,
    input  logic [WORD_W-1:0] reg_word_i,
    output logic [WORD_W-1:0] merged_o,
    output logic [LANES-1:0]  byte_en_o
);

    merge_op_e         op;
    route_t            route;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] dst_word;
    logic [WORD_W-1:0] aligned;
    logic [OFFS_W-1:0] shamt;

    assign op       = merge_op_e'(op_i);
    assign route    = op_route(op);
    assign src_word = route.is_store ? reg_word_i : mem_word_i;
    assign dst_word = route.is_store ? mem_word_i : reg_word_i;

    ulm_lane_mask #(.LANES(LANES), .OFFS_W(OFFS_W)) u_mask (
        .op_i    (op),
        .offs_i  (offs_i),
        .mask_o  (byte_en_o),
        .shamt_o (shamt)
    );

    ulm_aligner #(.LANE_W(LANE_W), .LANES(LANES), .OFFS_W(OFFS_W)) u_align (
        .src_i      (src_word),
        .shift_up_i (route.shift_up),
        .shamt_i    (shamt),
        .aligned_o  (aligned)
    );

    ulm_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .aligned_i (aligned),
        .dst_i     (dst_word),
        .mask_i    (byte_en_o),
        .merged_o  (merged_o)
    );

endmodule

// File: rtl/unaligned_merge_chk.sv
module unaligned_merge_chk
    import ulm_pkg::*;
#(
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF,
    localparam int WORD_W = LANE_W * LANES,
    localparam int OFFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input logic [1:0]        op_i,
    input logic [OFFS_W-1:0] offs_i,
    input logic [WORD_W-1:0] mem_word_i,
    input logic [WORD_W-1:0] reg_word_i,
    input logic [WORD_W-1:0] merged_o,
    input logic [LANES-1:0]  byte_en_o
);

    always_comb begin
        int  k;
        int  want;
        logic keep_ok;
        logic [WORD_W-1:0] dst;
        k = int'(offs_i);
        dst = op_i[1] ? mem_word_i : reg_word_i;
        keep_ok = 1'b1;
        for (int l = 0; l < LANES; l++)
            if (!byte_en_o[l] && merged_o[l*LANE_W +: LANE_W] != dst[l*LANE_W +: LANE_W])
                keep_ok = 1'b0;
        unique case (merge_op_e'(op_i))
            OP_LOAD_LEFT:  want = k + 1;
            OP_LOAD_RIGHT: want = (k == 0) ? 0 : LANES - k;
            OP_STORE_LEFT: want = k + 1;
            default:       want = LANES - k;
        endcase
        if (!$isunknown({op_i, offs_i, mem_word_i, reg_word_i})) begin
            assert_lanes_kept_R7: assert (keep_ok);
            assert_enable_count_R6: assert ($countones(byte_en_o) == want);
            assert_lwr_zero_R3: assert (!(op_i == OP_LOAD_RIGHT && k == 0)
                                        || (merged_o == reg_word_i && byte_en_o == '0));
            assert_lwl_full_R1: assert (!(op_i == OP_LOAD_LEFT && k == LANES - 1)
                                        || merged_o == mem_word_i);
            assert_lwr_low_R2: assert (!(op_i == OP_LOAD_RIGHT && k != 0)
                                       || merged_o[LANE_W-1:0] == mem_word_i[k*LANE_W +: LANE_W]);
            assert_swl_full_R4: assert (!(op_i == OP_STORE_LEFT && k == LANES - 1)
                                        || merged_o == reg_word_i);
            assert_swr_zero_R5: assert (!(op_i == OP_STORE_RIGHT && k == 0)
                                        || merged_o == reg_word_i);
        end
    end

endmodule

bind unaligned_merge unaligned_merge_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .op_i       (op_i),
    .offs_i     (offs_i),
    .mem_word_i (mem_word_i),
    .reg_word_i (reg_word_i),
    .merged_o   (merged_o),
    .byte_en_o  (byte_en_o)
);

// File: tb/unaligned_merge_tb.sv
module unaligned_merge_tb;

    logic        clk = 1'b0;
    logic [1:0]  op_i;
    logic [1:0]  offs_i;
    logic [31:0] mem_word_i;
    logic [31:0] reg_word_i;
    logic [31:0] merged_o;
    logic [3:0]  byte_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] bytes [0:15];

    always #5 clk = ~clk;

    unaligned_merge u_dut (
        .op_i       (op_i),
        .offs_i     (offs_i),
        .mem_word_i (mem_word_i),
        .reg_word_i (reg_word_i),
        .merged_o   (merged_o),
        .byte_en_o  (byte_en_o)
    );

    function automatic logic [31:0] exp_merge(input int op, input int k,
                                              input logic [31:0] m, input logic [31:0] r);
        case (op)
            0: case (k)
                   0: return (m << 24) | (r & 32'h00ff_ffff);
                   1: return (m << 16) | (r & 32'h0000_ffff);
                   2: return (m << 8)  | (r & 32'h0000_00ff);
                   default: return m;
               endcase
            1: case (k)
                   0: return r;
                   1: return (r & 32'hff00_0000) | (m >> 8);
                   2: return (r & 32'hffff_0000) | (m >> 16);
                   default: return (r & 32'hffff_ff00) | (m >> 24);
               endcase
            2: case (k)
                   0: return (m & 32'hffff_ff00) | (r >> 24);
                   1: return (m & 32'hffff_0000) | (r >> 16);
                   2: return (m & 32'hff00_0000) | (r >> 8);
                   default: return r;
               endcase
            default: case (k)
                   0: return r;
                   1: return (r << 8)  | (m & 32'h0000_00ff);
                   2: return (r << 16) | (m & 32'h0000_ffff);
                   default: return (r << 24) | (m & 32'h00ff_ffff);
               endcase
        endcase
    endfunction

    function automatic logic [3:0] exp_mask(input int op, input int k);
        logic [15:0] t;
        case (op)
            0: t = 16'hFEC8;
            1: t = 16'h1370;
            2: t = 16'hF731;
            default: t = 16'h8CEF;
        endcase
        return t[k*4 +: 4];
    endfunction

    function automatic logic [31:0] lanes_to_bits(input logic [3:0] m);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) v[i*8 +: 8] = {8{m[i]}};
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input int op, input int k, input logic [31:0] m, input logic [31:0] r);
        @(negedge clk);
        op_i = 2'(op);
        offs_i = 2'(k);
        mem_word_i = m;
        reg_word_i = r;
        #1;
    endtask

    function automatic logic [31:0] word_at(input int base);
        return {bytes[base+3], bytes[base+2], bytes[base+1], bytes[base]};
    endfunction

    task automatic test_op(input int op, input string req);
        logic [31:0] pm [0:1];
        logic [31:0] pr [0:1];
        pm[0] = 32'h4433_2211; pr[0] = 32'hDDCC_BBAA;
        pm[1] = 32'h0F1E_2D3C; pr[1] = 32'hF0E1_D2C3;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 4; k++) begin
                apply(op, k, pm[p], pr[p]);
                check(req, merged_o, exp_merge(op, k, pm[p], pr[p]));
            end
    endtask

    task automatic test_lwr_zero_R3();
        apply(1, 0, 32'h1234_5678, 32'h9ABC_DEF0);
        check("R3 data", merged_o, 32'h9ABC_DEF0);
        check("R3 enable", {28'd0, byte_en_o}, 32'd0);
    endtask

    task automatic test_enables_R6();
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 4; k++) begin
                apply(op, k, 32'h0, 32'h0);
                check("R6", {28'd0, byte_en_o}, {28'd0, exp_mask(op, k)});
            end
    endtask

    // Source all ones, destination all zeros: the result must equal the lane mask.
    task automatic test_keep_R7();
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 4; k++) begin
                if (op < 2) apply(op, k, 32'hFFFF_FFFF, 32'h0);
                else        apply(op, k, 32'h0, 32'hFFFF_FFFF);
                check("R7", merged_o, lanes_to_bits(exp_mask(op, k)));
            end
    endtask

    task automatic test_load_pair_R8();
        logic [31:0] r;
        for (int i = 0; i < 16; i++) bytes[i] = 8'(8'h3B + i * 29);
        for (int k = 0; k < 4; k++) begin
            int a;
            a = 4 + k;
            r = 32'hDEAD_BEEF;
            apply(1, a & 3, word_at(a & ~3), r);
            r = merged_o;
            apply(0, (a + 3) & 3, word_at((a + 3) & ~3), r);
            check("R8", merged_o, {bytes[a+3], bytes[a+2], bytes[a+1], bytes[a]});
        end
    endtask

    task automatic test_store_pair_R9();
        logic [31:0] v;
        logic [31:0] w;
        for (int k = 0; k < 4; k++) begin
            int a;
            int b;
            for (int i = 0; i < 16; i++) bytes[i] = 8'(8'h5A ^ (i * 17));
            a = 4 + k;
            v = 32'hC1D2_E3F4 ^ (k * 32'h0101_0101);
            b = a & ~3;
            apply(3, a & 3, word_at(b), v);
            w = merged_o;
            {bytes[b+3], bytes[b+2], bytes[b+1], bytes[b]} = w;
            b = (a + 3) & ~3;
            apply(2, (a + 3) & 3, word_at(b), v);
            w = merged_o;
            {bytes[b+3], bytes[b+2], bytes[b+1], bytes[b]} = w;
            check("R9 word", {bytes[a+3], bytes[a+2], bytes[a+1], bytes[a]}, v);
            check("R9 below", {24'd0, bytes[a-1]}, {24'd0, 8'(8'h5A ^ ((a - 1) * 17))});
            check("R9 above", {24'd0, bytes[a+4]}, {24'd0, 8'(8'h5A ^ ((a + 4) * 17))});
        end
    endtask

    initial begin
        op_i = 2'd0; offs_i = 2'd0; mem_word_i = '0; reg_word_i = '0;
        repeat (2) @(negedge clk);
        test_op(0, "R1");
        test_op(1, "R2");
        test_lwr_zero_R3();
        test_op(2, "R4");
        test_op(3, "R5");
        test_enables_R6();
        test_keep_R7();
        test_load_pair_R8();
        test_store_pair_R9();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule